// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block holds the control state that lets a single hart take a non-maskable interrupt and later go back to the code it interrupted. When the NMI request line is high and the block's internal enable bit is set, the block records the interrupted PC, the cause and the privilege mode in its own four CSRs. It then clears the enable bit and steers fetch to a fixed handler address in machine mode. A dedicated return strobe restores the saved PC and privilege mode and sets the enable bit again.

While the enable bit is clear, the block asserts a global interrupt-inhibit output and ignores further NMI requests. Any exception reported in this window is sent to a separate NMI exception vector. For such an exception the block drives update strobes for mepc, mcause and mstatus.MPP into the main CSR file. Both vectors are parameters.

Redirect, strobes and read data are combinational from the current inputs and state. All CSR and enable updates take effect at the next rising clock edge.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: After synchronous active-low reset, irq_inhibit_o is 0 (enable bit set) and all four NMI CSRs read as 0, except that the status register shows the enable bit.
- R2: The NMI CSRs decode at addresses 0x350 (scratch), 0x351 (saved PC), 0x352 (cause) and 0x353 (status), and csr_hit_o is 1 only for these addresses. Read data is 0 for any other address. A write is stored only when cur_priv_i is machine mode (2'b11); writes from lower privilege leave the register unchanged.
- R3: Bit 0 of the saved-PC register always reads 0, whatever value was written or captured.
- R4: In the status register, bits [12:11] hold a privilege mode using the mstatus.MPP encoding and bit 3 shows the enable bit. All other bits read 0. A machine-mode write with bit 3 = 1 sets the enable bit; writing bit 3 = 0 never clears it.
- R5: When nmi_req_i is 1 and the enable bit is set, the block drives redirect_o = 1, redirect_pc_o = NMI_VEC and next_priv_o = 2'b11 in that cycle. From the next cycle on, the saved PC is cur_pc_i with bit 0 cleared, the cause is bit XLEN-1 set with nmi_cause_i in the low bits, status[12:11] is cur_priv_i, and the enable bit is clear.
- R6: A taken NMI outranks an exception and a return strobe in the same cycle. The block drives no mepc, mcause or MPP strobe and does not report an illegal return.
- R7: While the enable bit is clear, irq_inhibit_o is 1 and nmi_req_i causes no redirect.
- R8: An exception (exc_valid_i) while the enable bit is clear drives all three update strobes with mepc = cur_pc_i, mcause = exc_cause_i and MPP = 2'b11. It also redirects to NMI_EXC_VEC in machine mode and leaves the NMI CSRs unchanged.
- R9: An exception while the enable bit is set produces no redirect, no strobe and no state change from this block.
- R10: A return strobe in machine mode with no exception redirects to the saved PC with next_priv_o equal to status[12:11], and sets the enable bit for the next cycle.
- R11: A return strobe outside machine mode drives illegal_o = 1, gives no redirect and leaves the enable bit unchanged.
- R12: A CSR write in a cycle that takes an NMI or flags an exception is discarded.
- R13: When redirect_o is 0, redirect_pc_o is 0 and next_priv_o equals cur_priv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req_i | input | 1 | Level-sensitive NMI request |
| nmi_cause_i | input | CAUSE_W | NMI cause code |
| cur_pc_i | input | XLEN | PC of the instruction in the trap slot |
| cur_priv_i | input | 2 | Current privilege mode |
| exc_valid_i | input | 1 | Exception flagged this cycle |
| exc_cause_i | input | XLEN | Exception cause value |
| mnret_i | input | 1 | Decoded return-from-NMI strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| csr_hit_o | output | 1 | Address is an NMI CSR |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | XLEN | Redirect target |
| next_priv_o | output | 2 | Privilege mode for the next instruction |
| irq_inhibit_o | output | 1 | Hold off all interrupts |
| mepc_we_o | output | 1 | mepc update strobe |
| mepc_wdata_o | output | XLEN | mepc update value |
| mcause_we_o | output | 1 | mcause update strobe |
| mcause_wdata_o | output | XLEN | mcause update value |
| mpp_we_o | output | 1 | mstatus.MPP update strobe |
| mpp_wdata_o | output | 2 | mstatus.MPP update value |
| illegal_o | output | 1 | Return executed outside machine mode |

## Verification
A wrong enable bit shows up in the same cycle on irq_inhibit_o. It also shows one cycle later, when an NMI request is either taken twice or lost, or when an exception goes to the wrong vector. A bad saved PC, cause or privilege appears on csr_rdata_o as soon as the register is read. It also appears on redirect_pc_o and next_priv_o in the cycle of the next return. The bench keeps a reference model of the four registers and the enable bit, and compares every output in every cycle. Any divergence is therefore reported in the cycle it first becomes visible.

// File: rtl/rnmi_pkg.sv
// Shared types and constants for the resumable NMI trap controller.
// Assumes the standard two-bit privilege encoding (3 = machine mode).
package rnmi_pkg;
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_NMI     = 3'd1,
        ACT_NMI_EXC = 3'd2,
        ACT_RETURN  = 3'd3,
        ACT_ILLEGAL = 3'd4
    } rnmi_act_e;

    localparam logic [1:0]  PRIV_M       = 2'b11;
    localparam logic [11:0] CSR_NSCRATCH = 12'h350;
    localparam logic [11:0] CSR_NEPC     = 12'h351;
    localparam logic [11:0] CSR_NCAUSE   = 12'h352;
    localparam logic [11:0] CSR_NSTATUS  = 12'h353;
    localparam int          STAT_PRIV_LO = 11;
    localparam int          STAT_EN_BIT  = 3;
endpackage

// File: rtl/rnmi_arbiter.sv
// Chooses the single trap action for this cycle.
// Priority: NMI entry, then an exception (steered only while blocked), then the return strobe.
// Assumes exc_valid_i and mnret_i describe the same instruction slot.
module rnmi_arbiter
    import rnmi_pkg::*;
(
    input  logic       nmi_req_i,
    input  logic       exc_valid_i,
    input  logic       mnret_i,
    input  logic [1:0] cur_priv_i,
    input  logic       nmi_en_i,
    output rnmi_act_e  act_o
);
    // Fixed-priority selection of the cycle's action.
    always_comb begin
        if (nmi_req_i && nmi_en_i) begin
            act_o = ACT_NMI;
        end else if (exc_valid_i && !nmi_en_i) begin
            act_o = ACT_NMI_EXC;
        end else if (exc_valid_i) begin
            act_o = ACT_NONE;
        end else if (mnret_i && (cur_priv_i != PRIV_M)) begin
            act_o = ACT_ILLEGAL;
        end else if (mnret_i) begin
            act_o = ACT_RETURN;
        end else begin
            act_o = ACT_NONE;
        end
    end
endmodule

// File: rtl/rnmi_csr_bank.sv
// Holds the four NMI CSRs and the enable bit, and provides their read port.
// Trap events update the registers at the clock edge. A software write is taken only in
// machine mode, and only in a cycle with no NMI entry and no exception.
module rnmi_csr_bank
    import rnmi_pkg::*;
#(
    parameter int XLEN            = 32,
    parameter int CAUSE_W         = 8,
    parameter bit CAUSE_SUPPORTED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rnmi_act_e          act_i,
    input  logic [XLEN-1:0]    cur_pc_i,
    input  logic [1:0]         cur_priv_i,
    input  logic [CAUSE_W-1:0] nmi_cause_i,
    input  logic               exc_valid_i,
    input  logic [11:0]        csr_addr_i,
    input  logic               csr_we_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic               nmi_en_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [1:0]         saved_priv_o,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               csr_hit_o
);
    localparam int CAUSE_PAD = XLEN - 1 - CAUSE_W;

    logic [XLEN-1:0] scratch_q;
    logic [XLEN-1:1] epc_q;
    logic [XLEN-1:0] cause_q;
    logic [1:0]      priv_q;
    logic            en_q;
    logic [XLEN-1:0] entry_cause;
    logic            sw_wr;

    // Cause value loaded on entry; the parameter picks whether a code is recorded.
    generate
        if (CAUSE_SUPPORTED) begin : g_cause_code
            assign entry_cause = {1'b1, {CAUSE_PAD{1'b0}}, nmi_cause_i};
        end else begin : g_cause_flag
            assign entry_cause = {1'b1, {(XLEN-1){1'b0}}};
        end
    endgenerate

    // Software write qualification: machine mode, no entry, no exception this cycle.
    assign sw_wr = csr_we_i && (cur_priv_i == PRIV_M) && (act_i != ACT_NMI) && !exc_valid_i;

    // Register updates from trap events and from software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            epc_q     <= '0;
            cause_q   <= '0;
            priv_q    <= '0;
            en_q      <= 1'b1;
        end else if (act_i == ACT_NMI) begin
            epc_q   <= cur_pc_i[XLEN-1:1];
            cause_q <= entry_cause;
            priv_q  <= cur_priv_i;
            en_q    <= 1'b0;
        end else begin
            if (act_i == ACT_RETURN) begin
                en_q <= 1'b1;
            end
            if (sw_wr) begin
                unique case (csr_addr_i)
                    CSR_NSCRATCH: scratch_q <= csr_wdata_i;
                    CSR_NEPC:     epc_q     <= csr_wdata_i[XLEN-1:1];
                    CSR_NCAUSE:   cause_q   <= csr_wdata_i;
                    CSR_NSTATUS: begin
                        priv_q <= csr_wdata_i[STAT_PRIV_LO+1:STAT_PRIV_LO];
                        if (csr_wdata_i[STAT_EN_BIT]) begin
                            en_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; unlisted addresses and reserved status bits return zero.
    always_comb begin
        csr_rdata_o = '0;
        csr_hit_o   = 1'b1;
        unique case (csr_addr_i)
            CSR_NSCRATCH: csr_rdata_o = scratch_q;
            CSR_NEPC:     csr_rdata_o = {epc_q, 1'b0};
            CSR_NCAUSE:   csr_rdata_o = cause_q;
            CSR_NSTATUS: begin
                csr_rdata_o[STAT_PRIV_LO+1:STAT_PRIV_LO] = priv_q;
                csr_rdata_o[STAT_EN_BIT]                 = en_q;
            end
            default: csr_hit_o = 1'b0;
        endcase
    end

    assign nmi_en_o     = en_q;
    assign epc_o        = {epc_q, 1'b0};
    assign saved_priv_o = priv_q;

    assert_entry_clears_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_NMI) |=> !nmi_en_o);
    assert_entry_saves_context_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_NMI) |=> (epc_o[XLEN-1:1] == $past(cur_pc_i[XLEN-1:1])) &&
                               (saved_priv_o == $past(cur_priv_i)));
    assert_return_sets_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_RETURN) |=> nmi_en_o);
    assert_low_priv_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && (cur_priv_i != PRIV_M) && (act_i == ACT_NONE)) |=>
        ($stable(scratch_q) && $stable(epc_o) && $stable(cause_q) && $stable(priv_q) && $stable(nmi_en_o)));
    assert_status_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr_i == CSR_NSTATUS) |->
        ($countones(csr_rdata_o) <= 3) && !csr_rdata_o[0] && !csr_rdata_o[XLEN-1]);
endmodule

// File: rtl/rnmi_redirect.sv
// Turns the chosen action into fetch redirect, next privilege and main-CSR update strobes.
// Purely combinational; clk and rst_n are used only by the assertions.
module rnmi_redirect
    import rnmi_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] NMI_VEC     = '0,
    parameter logic [XLEN-1:0] NMI_EXC_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  rnmi_act_e       act_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic [1:0]      saved_priv_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [1:0]      cur_priv_i,
    input  logic [XLEN-1:0] exc_cause_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic [1:0]      next_priv_o,
    output logic            mepc_we_o,
    output logic [XLEN-1:0] mepc_wdata_o,
    output logic            mcause_we_o,
    output logic [XLEN-1:0] mcause_wdata_o,
    output logic            mpp_we_o,
    output logic [1:0]      mpp_wdata_o,
    output logic            illegal_o
);
    // Per-action output selection.
    always_comb begin
        redirect_o     = 1'b0;
        redirect_pc_o  = '0;
        next_priv_o    = cur_priv_i;
        mepc_we_o      = 1'b0;
        mepc_wdata_o   = '0;
        mcause_we_o    = 1'b0;
        mcause_wdata_o = '0;
        mpp_we_o       = 1'b0;
        mpp_wdata_o    = '0;
        illegal_o      = 1'b0;
        unique case (act_i)
            ACT_NMI: begin
                redirect_o    = 1'b1;
                redirect_pc_o = NMI_VEC;
                next_priv_o   = PRIV_M;
            end
            ACT_NMI_EXC: begin
                redirect_o     = 1'b1;
                redirect_pc_o  = NMI_EXC_VEC;
                next_priv_o    = PRIV_M;
                mepc_we_o      = 1'b1;
                mepc_wdata_o   = cur_pc_i;
                mcause_we_o    = 1'b1;
                mcause_wdata_o = exc_cause_i;
                mpp_we_o       = 1'b1;
                mpp_wdata_o    = PRIV_M;
            end
            ACT_RETURN: begin
                redirect_o    = 1'b1;
                redirect_pc_o = epc_i;
                next_priv_o   = saved_priv_i;
            end
            ACT_ILLEGAL: illegal_o = 1'b1;
            default: ;
        endcase
    end

    assert_exc_strobes_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mepc_we_o |-> (mcause_we_o && mpp_we_o && (mpp_wdata_o == PRIV_M) && (next_priv_o == PRIV_M)));
    assert_return_target_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_RETURN) |-> !redirect_pc_o[0]);
    assert_illegal_no_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !redirect_o && !mepc_we_o);
endmodule

// File: rtl/rnmi_trap_ctrl.sv
// Top of the resumable NMI trap controller: arbiter, CSR bank and redirect logic.
// Assumes one instruction slot per cycle, and that the pipeline applies redirect_o and the
// update strobes in the same cycle they are driven.
module rnmi_trap_ctrl
    import rnmi_pkg::*;
#(
    parameter int              XLEN            = 32,
    parameter int              CAUSE_W         = 8,
    parameter bit              CAUSE_SUPPORTED = 1'b1,
    parameter logic [XLEN-1:0] NMI_VEC         = 32'h0000_0100,
    parameter logic [XLEN-1:0] NMI_EXC_VEC     = 32'h0000_0200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_req_i,
    input  logic [CAUSE_W-1:0] nmi_cause_i,
    input  logic [XLEN-1:0]    cur_pc_i,
    input  logic [1:0]         cur_priv_i,
    input  logic               exc_valid_i,
    input  logic [XLEN-1:0]    exc_cause_i,
    input  logic               mnret_i,
    input  logic [11:0]        csr_addr_i,
    input  logic               csr_we_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               csr_hit_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [1:0]         next_priv_o,
    output logic               irq_inhibit_o,
    output logic               mepc_we_o,
    output logic [XLEN-1:0]    mepc_wdata_o,
    output logic               mcause_we_o,
    output logic [XLEN-1:0]    mcause_wdata_o,
    output logic               mpp_we_o,
    output logic [1:0]         mpp_wdata_o,
    output logic               illegal_o
);
    rnmi_act_e       act;
    logic            nmi_en;
    logic [XLEN-1:0] epc;
    logic [1:0]      saved_priv;

    rnmi_arbiter u_arb (
        .nmi_req_i  (nmi_req_i),
        .exc_valid_i(exc_valid_i),
        .mnret_i    (mnret_i),
        .cur_priv_i (cur_priv_i),
        .nmi_en_i   (nmi_en),
        .act_o      (act)
    );

    rnmi_csr_bank #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .CAUSE_SUPPORTED(CAUSE_SUPPORTED)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .cur_pc_i    (cur_pc_i),
        .cur_priv_i  (cur_priv_i),
        .nmi_cause_i (nmi_cause_i),
        .exc_valid_i (exc_valid_i),
        .csr_addr_i  (csr_addr_i),
        .csr_we_i    (csr_we_i),
        .csr_wdata_i (csr_wdata_i),
        .nmi_en_o    (nmi_en),
        .epc_o       (epc),
        .saved_priv_o(saved_priv),
        .csr_rdata_o (csr_rdata_o),
        .csr_hit_o   (csr_hit_o)
    );

    rnmi_redirect #(.XLEN(XLEN), .NMI_VEC(NMI_VEC), .NMI_EXC_VEC(NMI_EXC_VEC)) u_redir (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_i         (act),
        .epc_i         (epc),
        .saved_priv_i  (saved_priv),
        .cur_pc_i      (cur_pc_i),
        .cur_priv_i    (cur_priv_i),
        .exc_cause_i   (exc_cause_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .next_priv_o   (next_priv_o),
        .mepc_we_o     (mepc_we_o),
        .mepc_wdata_o  (mepc_wdata_o),
        .mcause_we_o   (mcause_we_o),
        .mcause_wdata_o(mcause_wdata_o),
        .mpp_we_o      (mpp_we_o),
        .mpp_wdata_o   (mpp_wdata_o),
        .illegal_o     (illegal_o)
    );

    // Interrupts are held off whenever the handler is active.
    assign irq_inhibit_o = !nmi_en;

    assert_blocked_nmi_no_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req_i && irq_inhibit_o && !exc_valid_i) |-> !redirect_o || (redirect_pc_o != NMI_VEC));
    assert_nmi_beats_exception_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req_i && !irq_inhibit_o) |-> redirect_o && !mepc_we_o && !illegal_o);
    assert_inhibit_after_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req_i && !irq_inhibit_o) |=> irq_inhibit_o);
endmodule

// File: tb/test_rnmi_trap_ctrl.sv
// Self-checking bench: reference model of the NMI state, directed corners, then seeded random.
module test_rnmi_trap_ctrl;
    localparam logic [31:0] NV = 32'h0000_0100;
    localparam logic [31:0] EV = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0;
    logic [7:0]  nmi_cause = '0;
    logic [31:0] cur_pc = '0;
    logic [1:0]  cur_priv = 2'b11;
    logic        exc_valid = 1'b0;
    logic [31:0] exc_cause = '0;
    logic        mnret = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata, redirect_pc, mepc_wdata, mcause_wdata;
    logic        csr_hit, redirect, irq_inhibit, mepc_we, mcause_we, mpp_we, illegal;
    logic [1:0]  next_priv, mpp_wdata;

    int errors = 0;
    int checks = 0;

    // reference model state
    bit          m_en;
    logic [31:0] m_scr, m_epc, m_cause;
    logic [1:0]  m_priv;

    always #5 clk = ~clk;

    rnmi_trap_ctrl #(.NMI_VEC(NV), .NMI_EXC_VEC(EV)) i_rnmi_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req), .nmi_cause_i(nmi_cause),
        .cur_pc_i(cur_pc), .cur_priv_i(cur_priv), .exc_valid_i(exc_valid),
        .exc_cause_i(exc_cause), .mnret_i(mnret), .csr_addr_i(csr_addr),
        .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .csr_hit_o(csr_hit), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
        .next_priv_o(next_priv), .irq_inhibit_o(irq_inhibit), .mepc_we_o(mepc_we),
        .mepc_wdata_o(mepc_wdata), .mcause_we_o(mcause_we), .mcause_wdata_o(mcause_wdata),
        .mpp_we_o(mpp_we), .mpp_wdata_o(mpp_wdata), .illegal_o(illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h350: return m_scr;
            12'h351: return m_epc;
            12'h352: return m_cause;
            12'h353: return {19'b0, m_priv, 7'b0, m_en, 3'b0};
            default: return 32'h0;
        endcase
    endfunction

    // 1 = NMI, 2 = NMI exception, 3 = return, 4 = illegal, 0 = none
    function automatic int exp_act();
        if (nmi_req && m_en) return 1;
        if (exc_valid && !m_en) return 2;
        if (exc_valid) return 0;
        if (mnret && cur_priv != 2'b11) return 4;
        if (mnret) return 3;
        return 0;
    endfunction

    // Drive one cycle of inputs, check all outputs, then advance the model at the edge.
    task automatic cyc(input string tag, input bit nr, input logic [7:0] nc, input logic [31:0] pc,
                       input logic [1:0] pv, input bit ev, input logic [31:0] ec, input bit rt,
                       input bit we, input logic [11:0] ad, input logic [31:0] wd);
        int a;
        string t;
        bit    e_rd;
        logic [31:0] e_pc;
        logic [1:0]  e_pv;
        @(negedge clk);
        nmi_req = nr; nmi_cause = nc; cur_pc = pc; cur_priv = pv; exc_valid = ev;
        exc_cause = ec; mnret = rt; csr_we = we; csr_addr = ad; csr_wdata = wd;
        #2;
        a = exp_act();
        t = tag;
        if (t == "") t = (a == 1) ? "R5" : (a == 2) ? "R8" : (a == 3) ? "R10" :
                         (a == 4) ? "R11" : ev ? "R9" : "R13";
        e_rd = (a == 1) || (a == 2) || (a == 3);
        e_pc = (a == 1) ? NV : (a == 2) ? EV : (a == 3) ? m_epc : 32'h0;
        e_pv = (a == 1 || a == 2) ? 2'b11 : (a == 3) ? m_priv : pv;
        check(redirect == e_rd, t, "redirect", {31'b0, redirect}, {31'b0, e_rd});
        check(redirect_pc == e_pc, t, "redirect_pc", redirect_pc, e_pc);
        check(next_priv == e_pv, t, "next_priv", {30'b0, next_priv}, {30'b0, e_pv});
        check({mepc_we, mcause_we, mpp_we} == {3{a == 2}}, (a == 1) ? "R6" : t, "strobes",
              {29'b0, mepc_we, mcause_we, mpp_we}, {29'b0, {3{a == 2}}});
        if (a == 2) begin
            check(mepc_wdata == pc && mcause_wdata == ec && mpp_wdata == 2'b11, "R8",
                  "strobe data", mepc_wdata ^ mcause_wdata, pc ^ ec);
        end
        check(illegal == (a == 4), t, "illegal", {31'b0, illegal}, {31'b0, a == 4});
        check(irq_inhibit == !m_en, m_en ? t : "R7", "irq_inhibit", {31'b0, irq_inhibit}, {31'b0, !m_en});
        check(csr_rdata == exp_read(ad), "R2", "csr_rdata", csr_rdata, exp_read(ad));
        check(csr_hit == (ad >= 12'h350 && ad <= 12'h353), "R2", "csr_hit",
              {31'b0, csr_hit}, {31'b0, ad >= 12'h350 && ad <= 12'h353});
        @(posedge clk);
        if (a == 1) begin
            m_epc = {pc[31:1], 1'b0};
            m_cause = {1'b1, 23'b0, nc};
            m_priv = pv;
            m_en = 1'b0;
        end else begin
            if (a == 3) m_en = 1'b1;
            if (we && pv == 2'b11 && !ev) begin
                case (ad)
                    12'h350: m_scr = wd;
                    12'h351: m_epc = {wd[31:1], 1'b0};
                    12'h352: m_cause = wd;
                    12'h353: begin
                        m_priv = wd[12:11];
                        if (wd[3]) m_en = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic rd(input string tag, input logic [11:0] ad, input logic [1:0] pv);
        cyc(tag, 0, 0, 32'h1000, pv, 0, 0, 0, 0, ad, 0);
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dummy;
        m_en = 1'b1; m_scr = '0; m_epc = '0; m_cause = '0; m_priv = '0;
        dummy = $urandom(32'h5eed_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register and the enable bit
        for (int k = 0; k < 4; k++) rd("R1", 12'h350 + 12'(k), 2'b11);
        check(irq_inhibit == 1'b0, "R1", "inhibit after reset", {31'b0, irq_inhibit}, 32'h0);
        // R2: low-privilege write is dropped; unrelated address reads zero
        cyc("R2", 0, 0, 32'h40, 2'b00, 0, 0, 0, 1, 12'h350, 32'hdead_beef);
        rd("R2", 12'h350, 2'b11);
        rd("R2", 12'h300, 2'b11);
        // R3: bit 0 of saved PC
        cyc("R3", 0, 0, 32'h40, 2'b11, 0, 0, 0, 1, 12'h351, 32'h0000_1235);
        rd("R3", 12'h351, 2'b11);
        // R4: reserved status bits, enable cannot be cleared by a write
        cyc("R4", 0, 0, 32'h40, 2'b11, 0, 0, 0, 1, 12'h353, 32'hffff_ffff);
        rd("R4", 12'h353, 2'b11);
        cyc("R4", 0, 0, 32'h40, 2'b11, 0, 0, 0, 1, 12'h353, 32'h0);
        rd("R4", 12'h353, 2'b11);
        // R6 and R12: NMI with exception, return and CSR write in the same cycle
        cyc("R6", 1, 8'h05, 32'h8000_1003, 2'b00, 1, 32'h2, 1, 1, 12'h350, 32'h1111_2222);
        for (int k = 0; k < 4; k++) rd("R12", 12'h350 + 12'(k), 2'b11);
        // R7: further NMI held off
        cyc("R7", 1, 8'h09, 32'h0000_0104, 2'b11, 0, 0, 0, 0, 12'h352, 0);
        // R8: exception inside handler
        cyc("R8", 0, 0, 32'h0000_0108, 2'b11, 1, 32'h0000_000d, 0, 0, 12'h351, 0);
        rd("R8", 12'h351, 2'b11);
        // R11: low-privilege status write and return change nothing
        cyc("R11", 0, 0, 32'h0000_010c, 2'b01, 0, 0, 0, 1, 12'h353, 32'h8);
        cyc("R11", 0, 0, 32'h0000_010c, 2'b01, 0, 0, 1, 0, 12'h353, 0);
        // R10: return in machine mode
        cyc("R10", 0, 0, 32'h0000_0110, 2'b11, 0, 0, 1, 0, 12'h353, 0);
        rd("R10", 12'h353, 2'b11);
        // R9: exception while enabled
        cyc("R9", 0, 0, 32'h0000_0114, 2'b00, 1, 32'h5, 0, 0, 12'h300, 0);
        // R4: enable set by a machine-mode status write
        cyc("R5", 1, 8'h03, 32'h0000_2000, 2'b01, 0, 0, 0, 0, 12'h353, 0);
        cyc("R4", 0, 0, 32'h0000_0100, 2'b11, 0, 0, 0, 1, 12'h353, 32'h0000_0808);
        rd("R4", 12'h353, 2'b11);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] pv;
            logic [11:0] ad;
            int r;
            r = $urandom_range(0, 3);
            pv = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
            r = $urandom_range(0, 4);
            ad = (r == 4) ? 12'h7c0 : 12'h350 + 12'(r);
            cyc("", ($urandom_range(0, 7) == 0), 8'($urandom), $urandom, pv,
                ($urandom_range(0, 7) == 0), $urandom, ($urandom_range(0, 5) == 0),
                ($urandom_range(0, 3) == 0), ad, $urandom);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule